// File: doc/BRIEF.md
# Configurable Down-Counting Timer Channel

This block is one timer channel that runs on the peripheral clock. A value register counts down at the clock rate divided by 1, 16 or 256. The counter can be 16 or 32 bits wide, and the width can be changed while the timer runs. When the counter wraps, it either restarts from full scale or reloads from a stored reload value. It can also stop after a single expiry. Software talks to the channel through four write strobes that share one data bus. One strobe sets the reload value and the count together. A second sets only the reload value, which takes effect at the next reload. A third writes the control word, and a fourth clears the interrupt.

The channel reports its live count, the stored reload value and the control word for readback, together with the raw interrupt bit, the masked interrupt bit and an interrupt line. The control word holds these fields:

- bit 7: run enable
- bit 6: periodic (0 means free-running)
- bit 5: interrupt enable
- bits 3:2: prescale code
- bit 1: 32-bit width
- bit 0: single-shot

Bit 4 and all bits above bit 7 are discarded on write.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control readback is 0x20, the reload readback is 0, the count is 0xFFFFFFFF, and the raw and masked interrupts and the interrupt line are 0.
- R2: A control write keeps only bits 7,6,5,3,2,1,0 of the data (mask 0xEF). All other bits read back as zero.
- R3: Prescale code 00 decrements once per clock, 01 once per 16 clocks, 10 once per 256 clocks, and the undefined code 11 once per 256 clocks.
- R4: A reload-and-count write (LOAD strobe) sets both the reload readback and the count to the written data. A reload-only write (BGLOAD strobe) changes the reload readback and leaves the count to continue its sequence.
- R5: From zero, a free-running counter steps to full scale (0xFFFF in 16-bit width, 0xFFFFFFFF in 32-bit width). A periodic counter steps to the reload value, limited to the active width.
- R6: In single-shot mode the count halts at zero after the step into zero. A control write with enable set, or a nonzero LOAD write, makes it count again.
- R7: In periodic mode a LOAD write whose active-width value is zero stops the count at zero.
- R8: In 16-bit width only the low half counts. The upper half of the count keeps the value last written or held, and a width change in either direction keeps all 32 bits.
- R9: The raw interrupt becomes 1 on a step from 1 to 0 and becomes 0 on an INTCLR write. The masked interrupt and the interrupt line equal the raw interrupt ANDed with control bit 5.
- R10: When a step into zero and an INTCLR write fall in the same cycle, the raw interrupt ends up 1.
- R11: While control bit 7 is 0 the count does not change, except through a LOAD write.
- R12: When the prescale code changes or the timer is disabled, the prescale divider restarts. The first step after such a change comes one full divide period after the control write.
- R13: In a cycle with a LOAD or control write, the count takes no prescaled step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_load | input | 1 | Write strobe: set reload value and count |
| wr_bgload | input | 1 | Write strobe: set reload value only |
| wr_ctrl | input | 1 | Write strobe: control word |
| wr_intclr | input | 1 | Write strobe: clear raw interrupt |
| wdata | input | 32 | Write data shared by all strobes |
| count_o | output | 32 | Current count, all 32 bits |
| load_o | output | 32 | Stored reload value |
| ctrl_o | output | 32 | Control word readback |
| ris_o | output | 1 | Raw interrupt status |
| mis_o | output | 1 | Masked interrupt status |
| irq_o | output | 1 | Interrupt line |

## Verification
The counting path is driven in several ways:

- 16-bit free-running with a nonzero upper half, which separates a wrap to full scale from a wrap that disturbs the upper half.
- 32-bit periodic runs with a background reload change, which separate the LOAD and BGLOAD write paths.
- Single-shot runs, which separate halting at zero from reloading.
- Divider sweeps over all four prescale codes, which tell the undefined code apart from divide-by-16 and show whether the divider restarts on a prescale change.

Same-cycle collisions are also applied: a step into zero together with an INTCLR write, and a LOAD write in a cycle where a tick is due. These show which write path takes priority.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    // Control word layout; bit positions are architectural.
    typedef struct packed {
        logic       enable;    // 7
        logic       periodic;  // 6
        logic       irq_en;    // 5
        logic       rsvd;      // 4 (always 0)
        logic [1:0] prescale;  // 3:2
        logic       wide;      // 1
        logic       single;    // 0
    } ctrl_t;

    localparam int          CTRL_W    = 8;
    localparam logic [7:0]  CTRL_KEEP = 8'hEF;
    localparam logic [7:0]  CTRL_RST  = 8'h20;

    // Divider exponent selected by the prescale code; code 3 aliases code 2.
    function automatic int unsigned div_shift(input logic [1:0] code,
                                              input int unsigned mid,
                                              input int unsigned top);
        case (code)
            2'b00:   return 0;
            2'b01:   return mid;
            default: return top;
        endcase
    endfunction

endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
    import cdt_pkg::*;
#(
    parameter int MID_SHIFT = 4,
    parameter int TOP_SHIFT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       tick
);
    localparam int CW = TOP_SHIFT;

    logic [CW-1:0] acc_q;
    logic [CW-1:0] last;

    always_comb begin
        last = CW'((32'd1 << div_shift(code, MID_SHIFT, TOP_SHIFT)) - 32'd1);
        tick = run && (acc_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + CW'(1);
        end
    end

    // R3
    div_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && code != 2'b00 && !restart) |=> !tick);

    // R12
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (restart && run && code != 2'b00) |=> (code == 2'b00 || !tick));

endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          en,
    input  logic          wide,
    input  logic          periodic,
    input  logic          single,
    input  logic          wr_load,
    input  logic          arm_set,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] reload,
    output logic [DW-1:0] value,
    output logic          hit
);
    localparam int HW = DW / 2;

    logic [DW-1:0] value_q;
    logic          armed_q;
    logic [DW-1:0] mask;
    logic [DW-1:0] low;
    logic [DW-1:0] new_low;
    logic          go;
    logic          load_nz;

    always_comb begin
        mask    = wide ? {DW{1'b1}} : {{(DW-HW){1'b0}}, {HW{1'b1}}};
        low     = value_q & mask;
        go      = adv && armed_q;
        hit     = go && (low == DW'(1));
        load_nz = (wdata & mask) != '0;
        if (low == '0) begin
            new_low = periodic ? (reload & mask) : mask;
        end else begin
            new_low = low - DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= {DW{1'b1}};
            armed_q <= 1'b1;
        end else begin
            if (wr_load) begin
                value_q <= wdata;
            end else if (go) begin
                value_q <= (value_q & ~mask) | (new_low & mask);
            end

            if (wr_load && periodic && !load_nz) begin
                armed_q <= 1'b0;
            end else if ((wr_load && load_nz) || arm_set) begin
                armed_q <= 1'b1;
            end else if (hit && single) begin
                armed_q <= 1'b0;
            end
        end
    end

    assign value = value_q;

    // R11
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_load) |=> $stable(value));

    // R6
    halt_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !wr_load) |=> $stable(value));

    // R9
    hit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> (value[HW-1:0] == '0));

endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int DW        = 32,
    parameter int MID_SHIFT = 4,
    parameter int TOP_SHIFT = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_load,
    input  logic          wr_bgload,
    input  logic          wr_ctrl,
    input  logic          wr_intclr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] load_o,
    output logic [DW-1:0] ctrl_o,
    output logic          ris_o,
    output logic          mis_o,
    output logic          irq_o
);
    ctrl_t         ctrl_q;
    ctrl_t         ctrl_new;
    logic [DW-1:0] load_q;
    logic          ris_q;
    logic          tick;
    logic          adv;
    logic          hit;
    logic          presc_restart;
    logic          arm_set;

    always_comb begin
        ctrl_new      = ctrl_t'(wdata[CTRL_W-1:0] & CTRL_KEEP);
        presc_restart = wr_ctrl && (ctrl_new.prescale != ctrl_q.prescale);
        arm_set       = wr_ctrl && ctrl_new.enable;
        adv           = tick && !wr_load && !wr_ctrl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= ctrl_t'(CTRL_RST);
            load_q <= '0;
            ris_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_new;
            end
            if (wr_load || wr_bgload) begin
                load_q <= wdata;
            end
            if (hit) begin
                ris_q <= 1'b1;
            end else if (wr_intclr) begin
                ris_q <= 1'b0;
            end
        end
    end

    cdt_prescaler #(
        .MID_SHIFT(MID_SHIFT),
        .TOP_SHIFT(TOP_SHIFT)
    ) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (ctrl_q.enable),
        .restart (presc_restart),
        .code    (ctrl_q.prescale),
        .tick    (tick)
    );

    cdt_counter #(
        .DW(DW)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .en       (ctrl_q.enable),
        .wide     (ctrl_q.wide),
        .periodic (ctrl_q.periodic),
        .single   (ctrl_q.single),
        .wr_load  (wr_load),
        .arm_set  (arm_set),
        .wdata    (wdata),
        .reload   (load_q),
        .value    (count_o),
        .hit      (hit)
    );

    assign load_o = load_q;
    assign ctrl_o = DW'(ctrl_q);
    assign ris_o  = ris_q;
    assign mis_o  = ris_q & ctrl_q.irq_en;
    assign irq_o  = mis_o;

    // R10
    tick_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> ris_o);

    // R9
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_intclr && !hit) |=> !ris_o);

    // R13
    load_exact_chk: assert property (@(posedge clk) disable iff (rst)
        wr_load |=> (count_o == $past(wdata)));

endmodule

// File: tb/sim_cdt_timer.sv
module sim_cdt_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_load = 1'b0, wr_bgload = 1'b0, wr_ctrl = 1'b0, wr_intclr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] count_o, load_o, ctrl_o;
    logic        ris_o, mis_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    cdt_timer u0 (
        .clk(clk), .rst(rst), .wr_load(wr_load), .wr_bgload(wr_bgload),
        .wr_ctrl(wr_ctrl), .wr_intclr(wr_intclr), .wdata(wdata),
        .count_o(count_o), .load_o(load_o), .ctrl_o(ctrl_o),
        .ris_o(ris_o), .mis_o(mis_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    logic [7:0]  m_ctrl;
    logic [31:0] m_load;
    longint      m_cnt;
    bit          m_run;
    int          m_pre;
    bit          m_ris;

    always @(posedge clk) begin
        int     div;
        bit     tk, go, hitv;
        longint span, low, nxt, lw;
        logic [7:0] nc;
        if (rst) begin
            m_ctrl = 8'h20; m_load = 0; m_cnt = 64'hFFFF_FFFF;
            m_run = 1; m_pre = 0; m_ris = 0;
        end else begin
            div  = (m_ctrl[3:2] == 2'd0) ? 1 : (m_ctrl[3:2] == 2'd1) ? 16 : 256;
            tk   = m_ctrl[7] && (m_pre == div - 1);
            span = m_ctrl[1] ? 64'h1_0000_0000 : 64'h1_0000;
            low  = m_cnt % span;
            go   = tk && m_run && !wr_load && !wr_ctrl;
            hitv = go && (low == 1);
            nc   = wdata[7:0] & 8'hEF;
            if (!m_ctrl[7] || (wr_ctrl && nc[3:2] != m_ctrl[3:2])) m_pre = 0;
            else if (tk) m_pre = 0;
            else m_pre = m_pre + 1;
            if (go) begin
                if (low == 0) nxt = m_ctrl[6] ? (longint'(m_load) % span) : span - 1;
                else nxt = low - 1;
                m_cnt = m_cnt - low + nxt;
                if (hitv && m_ctrl[0]) m_run = 0;
            end
            if (wr_load) begin
                m_load = wdata;
                m_cnt  = longint'(wdata);
                lw     = longint'(wdata) % span;
                if (m_ctrl[6] && lw == 0) m_run = 0;
                else if (lw != 0) m_run = 1;
            end
            if (wr_bgload) m_load = wdata;
            if (wr_ctrl) begin
                m_ctrl = nc;
                if (nc[7]) m_run = 1;
            end
            if (hitv) m_ris = 1;
            else if (wr_intclr) m_ris = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 count vs model", count_o, m_cnt[31:0]);
            chk("R4 reload vs model", load_o, m_load);
            chk("R2 control vs model", ctrl_o, {24'h0, m_ctrl});
            chk("R9 raw irq vs model", {31'h0, ris_o}, {31'h0, m_ris});
            chk("R9 masked irq vs model", {30'h0, mis_o, irq_o},
                {30'h0, m_ris & m_ctrl[5], m_ris & m_ctrl[5]});
        end
    end

    // Strobe kinds: 1 load, 2 bgload, 4 control, 8 intclr.
    task automatic put(input logic [3:0] kind, input logic [31:0] d);
        wr_load = kind[0]; wr_bgload = kind[1]; wr_ctrl = kind[2]; wr_intclr = kind[3];
        wdata = d;
        @(negedge clk);
        wr_load = 0; wr_bgload = 0; wr_ctrl = 0; wr_intclr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 count", count_o, 32'hFFFF_FFFF);
        chk("R1 reload", load_o, 32'h0);
        chk("R1 control", ctrl_o, 32'h20);
        chk("R1 irq", {29'h0, ris_o, mis_o, irq_o}, 32'h0);

        // R2 masking
        put(4, 32'hFFFF_FF7F);
        chk("R2 masked control", ctrl_o, 32'h6F);
        put(4, 32'h20);

        // 16-bit free-running with an upper half
        put(1, 32'h00AB_0003);
        chk("R4 load sets count", count_o, 32'h00AB_0003);
        put(4, 32'hA0);
        chk("R13 no step in control cycle", count_o, 32'h00AB_0003);
        idle(2);
        chk("R3 div1 steps", count_o, 32'h00AB_0001);
        idle(1);
        chk("R9 raw set at zero", {31'h0, ris_o}, 32'h1);
        chk("R9 line follows enable", {31'h0, irq_o}, 32'h1);
        idle(1);
        chk("R5 free wrap 16", count_o, 32'h00AB_FFFF);
        put(8, 0);
        chk("R9 intclr clears", {31'h0, ris_o}, 32'h0);
        put(1, 32'h00AB_0010);
        chk("R13 load while running", count_o, 32'h00AB_0010);

        // R11 freeze
        put(4, 32'h20);
        hold = count_o;
        idle(5);
        chk("R11 frozen", count_o, hold);

        // R8 width switching
        put(1, 32'h1234_0002);
        put(4, 32'hA0);
        idle(3);
        chk("R8 upper kept 16", count_o, 32'h1234_FFFF);
        put(4, 32'h22);
        chk("R8 to 32 keeps all", count_o, 32'h1234_FFFF);
        put(4, 32'hA2);
        idle(1);
        chk("R8 32 continues", count_o, 32'h1234_FFFE);
        put(4, 32'h22);

        // periodic 32-bit
        put(1, 3);
        put(4, 32'hE2);
        idle(4);
        chk("R5 periodic reload", count_o, 32'd3);
        put(2, 9);
        chk("R4 bgload leaves count", count_o, 32'd2);
        chk("R4 bgload reload", load_o, 32'd9);
        idle(3);
        chk("R4 bgload used at reload", count_o, 32'd9);

        // R7
        put(1, 0);
        idle(5);
        chk("R7 zero load stops", count_o, 32'd0);

        // R6 single shot
        put(8, 0);
        put(4, 32'hE3);
        put(1, 2);
        idle(2);
        chk("R6 reached zero", count_o, 32'd0);
        idle(5);
        chk("R6 halted", count_o, 32'd0);
        put(4, 32'hE3);
        idle(1);
        chk("R6 restart by control", count_o, 32'd2);
        idle(3);

        // R10 collision
        put(8, 0);
        put(1, 1);
        put(8, 0);
        chk("R10 tick beats clear", {31'h0, ris_o}, 32'h1);
        put(8, 0);
        chk("R9 plain clear", {31'h0, ris_o}, 32'h0);

        // masked off
        put(4, 32'h82);
        put(1, 1);
        idle(1);
        chk("R9 raw with enable off", {31'h0, ris_o}, 32'h1);
        chk("R9 line masked", {30'h0, mis_o, irq_o}, 32'h0);
        put(8, 0);

        // R3 and R12 dividers
        put(4, 32'h02);
        put(1, 100);
        put(4, 32'h86);
        idle(15);
        chk("R12 no early step", count_o, 32'd100);
        idle(1);
        chk("R12 first step after 16", count_o, 32'd99);
        idle(16);
        chk("R3 div16", count_o, 32'd98);
        put(4, 32'h8A);
        hold = count_o;
        idle(255);
        chk("R12 div256 wait", count_o, hold);
        idle(1);
        chk("R3 div256", count_o, hold - 1);
        put(4, 32'h8E);
        hold = count_o;
        idle(255);
        chk("R3 code11 wait", count_o, hold);
        idle(1);
        chk("R3 code11 is 256", count_o, hold - 1);

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule